// File: doc/BRIEF.md
# Memory Pattern Fill Engine

The block is a single-channel engine that writes a repeating 64-bit pattern over a region of memory. Software sets the region through a small word-addressed register port: a start address, a length in bytes, and the two 32-bit halves of the pattern. It then selects fill mode and writes a start command. The engine sends one 64-bit write beat per accepted handshake on a valid/ready memory port. Each beat goes to the next 8-byte address, until the whole region has been covered.

A command register drives a three-state channel: idle, active and paused. Start, stop, pause and restart are each honoured only in the states where they make sense. Any other command is dropped and sets a sticky error flag. A pause can fall in the middle of a block, and a later restart continues from the first beat that was not yet accepted. Software polls the status field until it reads idle, or watches the one-cycle completion pulse, before it programs the next block.

The configuration word holds a register-protect bit and two 3-bit burst-limit fields. The operating mode is shown in the configuration word but is changed only through its own register.

Top module: `mfe_fill_engine`

Register word index on `reg_addr_i`: 0 config, 1 mode, 2 start address, 3 length, 4 pattern low, 5 pattern high, 6 command/status, 7 reads zero.

## Requirements
- R1: After reset the status reads idle, the error flag is clear, `mem_valid_o` and `done_o` are low, the mode is 0, and the config word reads 0x441 (protect bit 0 set, source burst bits [6:4] = 4, destination burst bits [10:8] = 4, mode shown at bits [13:12]).
- R2: Command/status reads give the status in bits [1:0] (0 idle, 1 active, 2 paused; 3 never occurs) and the sticky error flag in bit 8.
- R3: A start command (command bit 0) is taken only when the channel is idle, the mode is 1 (fill) and the length is valid. The engine then writes beats to address A, A+8, A+16 and so on, for length/8 beats, each carrying {pattern_high, pattern_low}. A start in any other case is rejected.
- R4: A length is valid only when it is a multiple of 8 and lies in [MIN_SIZE, MAX_SIZE] (defaults 16 and 4096). A start with an invalid length leaves the channel idle, issues no beat and sets the error flag.
- R5: A beat counts only in a cycle where `mem_valid_o` and `mem_ready_i` are both high. While valid is high and ready is low, the address and data hold.
- R6: Pause (command bit 2) is taken only when the channel is active. It moves the channel to paused and drops `mem_valid_o`. Restart (command bit 3) is taken only when the channel is paused and resumes at the first unaccepted beat, so no beat is lost or repeated. A beat accepted in the same cycle as the pause counts.
- R7: Stop (command bit 1) returns an active channel to idle without `done_o`. Stop while idle does nothing and sets no flag. Stop while paused is illegal.
- R8: An illegal command, including a write with more than one of command bits [3:0] set, changes no state and sets the sticky error flag. Writing command bit 8 clears the flag, but a new illegal command in the same write leaves it set.
- R9: `done_o` is high for exactly one cycle, the cycle after the last beat is accepted, and the status reads idle in that cycle. When the last beat is accepted in the cycle a command is written, completion wins: the command is discarded and no flag is set.
- R10: A config write updates the protect bit and both burst fields but never the mode. Only a mode-register write (bits [1:0]) changes the mode.
- R11: While the protect bit is 1 and the channel is not idle, writes to the mode, address, length and pattern registers are ignored. With the protect bit at 0 they take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on index) |
| mem_valid_o | output | 1 | Write beat offered |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_addr_o | output | ADDR_W | Byte address of the beat |
| mem_data_o | output | 64 | Beat data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The acceptance of the final beat of a block can coincide with a pause or stop command written in the same cycle. The bench starts a two-beat block with ready held high and times a pause write to commit on the same edge as the second beat. It then expects idle status, one completion pulse, exactly two beats and a clear error flag. The same overlap with a non-final beat is provoked in the pause and stop tests, where the beat accepted on the command edge must be counted and later not repeated.

// File: rtl/mfe_pkg.sv
`timescale 1ns/1ps
package mfe_pkg;
  localparam int REG_AW = 3;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PAUSED = 2'd2
  } state_e;

  localparam logic [REG_AW-1:0] RA_CFG   = 3'd0;
  localparam logic [REG_AW-1:0] RA_MODE  = 3'd1;
  localparam logic [REG_AW-1:0] RA_DST   = 3'd2;
  localparam logic [REG_AW-1:0] RA_SIZE  = 3'd3;
  localparam logic [REG_AW-1:0] RA_PATLO = 3'd4;
  localparam logic [REG_AW-1:0] RA_PATHI = 3'd5;
  localparam logic [REG_AW-1:0] RA_CMD   = 3'd6;

  localparam logic [1:0] MODE_FILL = 2'd1;

  localparam int CB_START   = 0;
  localparam int CB_STOP    = 1;
  localparam int CB_PAUSE   = 2;
  localparam int CB_RESTART = 3;
  localparam int CB_CLR     = 8;
endpackage

// File: rtl/mfe_regs.sv
`timescale 1ns/1ps
module mfe_regs
  import mfe_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] MIN_SIZE = 32'd16,
  parameter logic [31:0] MAX_SIZE = 32'd4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  output logic              prot_o,
  output logic [2:0]        src_burst_o,
  output logic [2:0]        dst_burst_o,
  output logic [1:0]        mode_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [31:0]       size_o,
  output logic [DATA_W-1:0] pattern_o,
  output logic              size_ok_o
);
  logic        open;
  logic [31:0] pat_lo_q, pat_hi_q;

  // protected fields are frozen while a block is in flight
  assign open = !(prot_o && busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_o      <= 1'b1;
      src_burst_o <= 3'd4;
      dst_burst_o <= 3'd4;
      mode_o      <= 2'd0;
      dst_o       <= '0;
      size_o      <= '0;
      pat_lo_q    <= '0;
      pat_hi_q    <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_CFG: begin
          prot_o      <= wdata_i[0];
          src_burst_o <= wdata_i[6:4];
          dst_burst_o <= wdata_i[10:8];
        end
        RA_MODE:  if (open) mode_o   <= wdata_i[1:0];
        RA_DST:   if (open) dst_o    <= wdata_i[ADDR_W-1:0];
        RA_SIZE:  if (open) size_o   <= wdata_i;
        RA_PATLO: if (open) pat_lo_q <= wdata_i;
        RA_PATHI: if (open) pat_hi_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign pattern_o = {pat_hi_q, pat_lo_q};
  assign size_ok_o = (size_o[2:0] == 3'd0) && (size_o >= MIN_SIZE) && (size_o <= MAX_SIZE);
endmodule

// File: rtl/mfe_chan_ctrl.sv
`timescale 1ns/1ps
module mfe_chan_ctrl
  import mfe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [3:0] cmd_i,
  input  logic       clr_i,
  input  logic       size_ok_i,
  input  logic       fill_mode_i,
  input  logic       fire_i,
  input  logic       last_i,
  output state_e     state_o,
  output logic       illegal_o,
  output logic       go_o,
  output logic       done_o
);
  state_e state_n;
  logic   bad, done_n;
  int     n_cmd;

  always_comb begin
    n_cmd   = $countones(cmd_i);
    state_n = state_o;
    bad     = 1'b0;
    go_o    = 1'b0;
    done_n  = 1'b0;
    if (state_o == ST_ACTIVE && fire_i && last_i) begin
      // completion wins over any command in the same cycle
      state_n = ST_IDLE;
      done_n  = 1'b1;
    end else if (cmd_we_i && n_cmd != 0) begin
      if (n_cmd > 1) begin
        bad = 1'b1;
      end else if (cmd_i[CB_START]) begin
        if (state_o == ST_IDLE && size_ok_i && fill_mode_i) begin
          state_n = ST_ACTIVE;
          go_o    = 1'b1;
        end else bad = 1'b1;
      end else if (cmd_i[CB_STOP]) begin
        if (state_o == ST_ACTIVE) state_n = ST_IDLE;
        else if (state_o == ST_PAUSED) bad = 1'b1;
      end else if (cmd_i[CB_PAUSE]) begin
        if (state_o == ST_ACTIVE) state_n = ST_PAUSED;
        else bad = 1'b1;
      end else begin
        if (state_o == ST_PAUSED) state_n = ST_ACTIVE;
        else bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o   <= ST_IDLE;
      illegal_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      state_o <= state_n;
      done_o  <= done_n;
      if (bad) illegal_o <= 1'b1;
      else if (cmd_we_i && clr_i) illegal_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mfe_beat_gen.sv
`timescale 1ns/1ps
module mfe_beat_gen #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [SIZE_W-4:0] beats_i,
  input  logic              fire_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int CNT_W = SIZE_W - 3;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(8);

  logic [CNT_W-1:0] rem_q;

  // address and remaining count are kept across pause for exact resume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      rem_q  <= '0;
    end else if (go_i) begin
      addr_o <= dst_i;
      rem_q  <= beats_i;
    end else if (fire_i) begin
      addr_o <= addr_o + STEP;
      rem_q  <= rem_q - CNT_W'(1);
    end
  end

  assign last_o = (rem_q == CNT_W'(1));
endmodule

// File: rtl/mfe_fill_engine.sv
`timescale 1ns/1ps
module mfe_fill_engine
  import mfe_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] MIN_SIZE = 32'd16,
  parameter logic [31:0] MAX_SIZE = 32'd4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_data_o,
  output logic              done_o
);
  localparam int SIZE_W = 32;

  state_e            state_w;
  logic              illegal_w, go_w, last_w, fire_w, size_ok_w, prot_w, cmd_we_w;
  logic [2:0]        src_b_w, dst_b_w;
  logic [1:0]        mode_w;
  logic [ADDR_W-1:0] dst_w;
  logic [31:0]       size_w;
  logic [63:0]       pat_w;

  assign cmd_we_w    = reg_we_i && (reg_addr_i == RA_CMD);
  assign mem_valid_o = (state_w == ST_ACTIVE);
  assign fire_w      = mem_valid_o && mem_ready_i;
  assign mem_data_o  = pat_w;

  mfe_regs #(.ADDR_W(ADDR_W), .MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(state_w != ST_IDLE),
    .prot_o(prot_w), .src_burst_o(src_b_w), .dst_burst_o(dst_b_w),
    .mode_o(mode_w), .dst_o(dst_w), .size_o(size_w), .pattern_o(pat_w),
    .size_ok_o(size_ok_w)
  );

  mfe_chan_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .cmd_we_i(cmd_we_w), .cmd_i(reg_wdata_i[3:0]), .clr_i(reg_wdata_i[CB_CLR]),
    .size_ok_i(size_ok_w), .fill_mode_i(mode_w == MODE_FILL),
    .fire_i(fire_w), .last_i(last_w),
    .state_o(state_w), .illegal_o(illegal_w), .go_o(go_w), .done_o(done_o)
  );

  mfe_beat_gen #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_beat (
    .clk_i, .rst_ni,
    .go_i(go_w), .dst_i(dst_w), .beats_i(size_w[SIZE_W-1:3]),
    .fire_i(fire_w), .addr_o(mem_addr_o), .last_o(last_w)
  );

  always_comb begin
    case (reg_addr_i)
      RA_CFG:   reg_rdata_o = {18'b0, mode_w, 1'b0, dst_b_w, 1'b0, src_b_w, 3'b0, prot_w};
      RA_MODE:  reg_rdata_o = {30'b0, mode_w};
      RA_DST:   reg_rdata_o = 32'(dst_w);
      RA_SIZE:  reg_rdata_o = size_w;
      RA_PATLO: reg_rdata_o = pat_w[31:0];
      RA_PATHI: reg_rdata_o = pat_w[63:32];
      RA_CMD:   reg_rdata_o = {23'b0, illegal_w, 6'b0, state_w};
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mfe_fill_engine_chk.sv
`timescale 1ns/1ps
module mfe_fill_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [2:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              done_o,
  input logic [1:0]        state_i,
  input logic [1:0]        mode_i,
  input logic              illegal_i
);
  logic cmd_wr, mode_wr;
  assign cmd_wr  = reg_we_i && (reg_addr_i == 3'd6);
  assign mode_wr = reg_we_i && (reg_addr_i == 3'd1);

  assert_status_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != 2'd3);

  assert_idle_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'd0 && !cmd_wr) |=> state_i == 2'd0);

  assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> $stable(mem_addr_o));

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_ready_i) |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(8));

  // R6, R7: paused only leaves towards active
  assert_paused_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 2'd2 |=> state_i != 2'd0);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_i && !(cmd_wr && reg_wdata_i[8])) |=> illegal_i);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_i == 2'd0 && !mem_valid_o));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_mode_only_own_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wr |=> $stable(mode_i));
endmodule

bind mfe_fill_engine mfe_fill_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_addr_o(mem_addr_o), .done_o(done_o), .state_i(state_w), .mode_i(mode_w),
  .illegal_i(illegal_w)
);

// File: tb/mfe_fill_engine_test.sv
`timescale 1ns/1ps
module mfe_fill_engine_test;
  localparam logic [2:0] A_CFG = 3'd0, A_MODE = 3'd1, A_DST = 3'd2, A_SIZE = 3'd3,
                         A_LO = 3'd4, A_HI = 3'd5, A_CMD = 3'd6;
  localparam int MAXS = 4096;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        mem_valid_o, mem_ready_i = 1'b0, done_o;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_data_o;

  int checks = 0, fails = 0, beats = 0, dones = 0, rdy_mode = 0;
  logic [31:0] exp_addr = '0;
  logic [63:0] exp_data = '0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  mfe_fill_engine uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    #1;
    mem_ready_i <= (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? ($urandom % 4 != 0) : 1'b0;
  end

  // beat and completion monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (mem_valid_o && mem_ready_i) begin
        chk("R3 R5 beat addr", 64'(mem_addr_o), 64'(exp_addr));
        chk("R3 beat data", mem_data_o, exp_data);
        exp_addr = exp_addr + 32'd8;
        beats++;
      end
      if (done_o) dones++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk_i); #1;
    reg_addr_i = a;
    @(negedge clk_i);
    d = reg_rdata_o;
  endtask

  task automatic prog(input logic [31:0] dst, input logic [31:0] size, input logic [63:0] pat);
    wr(A_DST, dst); wr(A_SIZE, size); wr(A_LO, pat[31:0]); wr(A_HI, pat[63:32]);
    exp_addr = dst; exp_data = pat; beats = 0;
  endtask

  task automatic wait_idle(input int lim);
    logic [31:0] d;
    for (int i = 0; i < lim; i++) begin
      rd(A_CMD, d);
      if (d[1:0] == 2'd0) return;
    end
    chk("R3 block never ended", 64'(d[1:0]), 64'd0);
  endtask

  task automatic status(input string req, input logic [1:0] st, input logic fl);
    logic [31:0] d;
    rd(A_CMD, d);
    chk({req, " status"}, 64'(d[1:0]), 64'(st));
    chk({req, " flag"}, 64'(d[8]), 64'(fl));
  endtask

  task automatic reject_size(input logic [31:0] size);
    prog(32'h100, size, 64'h1);
    wr(A_CMD, 32'h1);
    repeat (3) @(posedge clk_i);
    status("R4 bad length", 2'd0, 1'b1);
    chk("R4 no beat", 64'(beats), 64'd0);
    wr(A_CMD, 32'h100);
  endtask

  initial begin
    repeat (400000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a0;
    int d0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(A_CFG, d);
    chk("R1 cfg default", 64'(d), 64'h441);
    status("R1", 2'd0, 1'b0);
    chk("R1 valid", 64'(mem_valid_o), 64'd0);
    chk("R1 done", 64'(done_o), 64'd0);

    // R3 start rejected in mode 0
    prog(32'h1000, 32'd64, 64'h0123_4567_89ab_cdef);
    wr(A_CMD, 32'h1);
    status("R3 mode0 start", 2'd0, 1'b1);
    wr(A_CMD, 32'h100);
    status("R8 clear", 2'd0, 1'b0);

    // R3 basic fill
    wr(A_MODE, 32'h1);
    rdy_mode = 1;
    prog(32'h1000, 32'd64, 64'hdead_beef_cafe_f00d);
    d0 = dones;
    wr(A_CMD, 32'h1);
    wait_idle(100);
    repeat (2) @(posedge clk_i);
    chk("R3 beat count", 64'(beats), 64'd8);
    chk("R9 one done", 64'(dones - d0), 64'd1);
    status("R3 after block", 2'd0, 1'b0);

    // R4 length limits
    reject_size(32'd8);
    reject_size(32'd20);
    reject_size(MAXS + 8);
    prog(32'h4000_0000, MAXS, 64'h5555_aaaa_0f0f_f0f0);
    wr(A_CMD, 32'h1);
    wait_idle(800);
    repeat (2) @(posedge clk_i);
    chk("R4 max length beats", 64'(beats), 64'(MAXS / 8));

    // R8 illegal in idle
    wr(A_CMD, 32'h4);
    status("R8 pause idle", 2'd0, 1'b1);
    wr(A_CMD, 32'h100);
    wr(A_CMD, 32'h8);
    status("R8 restart idle", 2'd0, 1'b1);
    wr(A_CMD, 32'h100);
    wr(A_CMD, 32'h3);
    status("R8 two bits", 2'd0, 1'b1);
    wr(A_CMD, 32'h100);
    wr(A_CMD, 32'h104);
    status("R8 clear with new illegal", 2'd0, 1'b1);
    wr(A_CMD, 32'h100);
    wr(A_CMD, 32'h2);
    status("R7 stop idle", 2'd0, 1'b0);

    // R6 pause/restart, beat on the pause edge counts
    prog(32'h2000, 32'd256, 64'h1111_2222_3333_4444);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h4);
    status("R6 paused", 2'd2, 1'b0);
    chk("R6 beats at pause", 64'(beats), 64'd2);
    repeat (4) @(posedge clk_i);
    chk("R6 no beat while paused", 64'(beats), 64'd2);
    wr(A_CMD, 32'h4);
    status("R8 pause while paused", 2'd2, 1'b1);
    wr(A_CMD, 32'h2);
    status("R7 stop while paused", 2'd2, 1'b1);
    wr(A_CMD, 32'h100);
    wr(A_CMD, 32'h8);
    wait_idle(100);
    repeat (2) @(posedge clk_i);
    chk("R6 total after restart", 64'(beats), 64'd32);

    // R7 stop active
    prog(32'h3000, 32'd256, 64'h7);
    d0 = dones;
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h2);
    status("R7 stop active", 2'd0, 1'b0);
    repeat (3) @(posedge clk_i);
    chk("R7 beats at stop", 64'(beats), 64'd2);
    chk("R7 no done", 64'(dones - d0), 64'd0);

    // R9 last beat and pause on the same edge
    prog(32'h5000, 32'd16, 64'h9);
    d0 = dones;
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h4);
    repeat (2) @(posedge clk_i);
    status("R9 completion wins", 2'd0, 1'b0);
    chk("R9 beats", 64'(beats), 64'd2);
    chk("R9 done", 64'(dones - d0), 64'd1);

    // R5 hold while not ready; R11 protect; R8 start while active
    rdy_mode = 0;
    prog(32'h6000, 32'd64, 64'h42);
    wr(A_CMD, 32'h1);
    @(negedge clk_i); a0 = mem_addr_o;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    chk("R5 addr held", 64'(mem_addr_o), 64'(a0));
    chk("R5 no beat", 64'(beats), 64'd0);
    wr(A_DST, 32'h7000);
    rd(A_DST, d);
    chk("R11 dst protected", 64'(d), 64'h6000);
    wr(A_MODE, 32'h2);
    rd(A_MODE, d);
    chk("R11 mode protected", 64'(d), 64'h1);
    wr(A_CMD, 32'h1);
    status("R8 start while active", 2'd1, 1'b1);
    wr(A_CMD, 32'h102);

    // R10 config write keeps mode
    wr(A_CFG, 32'h3230);
    rd(A_CFG, d);
    chk("R10 cfg keeps mode", 64'(d), 64'h1230);
    wr(A_CMD, 32'h1);
    wr(A_DST, 32'h7000);
    rd(A_DST, d);
    chk("R11 unprotected write", 64'(d), 64'h7000);
    wr(A_CMD, 32'h2);
    wr(A_CFG, 32'h441);

    // random blocks
    for (int it = 0; it < 16; it++) begin
      int nb;
      nb = 10 + int'($urandom % 30);
      rdy_mode = 2;
      prog($urandom & 32'hffff_fff8, 32'(nb * 8), {$urandom, $urandom});
      d0 = dones;
      wr(A_CMD, 32'h1);
      if ($urandom % 2 == 1) begin
        repeat ($urandom % 3) @(posedge clk_i);
        wr(A_CMD, 32'h4);
        status("R6 random pause", 2'd2, 1'b0);
        repeat (3) @(posedge clk_i);
        wr(A_CMD, 32'h8);
      end
      wait_idle(2000);
      repeat (2) @(posedge clk_i);
      chk("R3 random beats", 64'(beats), 64'(nb));
      chk("R9 random done", 64'(dones - d0), 64'd1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule